// File: doc/BRIEF.md
# Five-Level Phase-Disposition PWM Modulator

This block drives one leg of a five-level diode-clamped inverter. A single up/down counter sweeps a triangle between zero and a programmable half-period `H`. Four carriers are formed from it by adding fixed multiples of `H`, so they occupy four stacked amplitude bands and always move in phase. On every clock the signed reference sample is compared against all four carriers. The number of carriers it exceeds selects one of five output levels. That level is registered together with the matching eight-bit gate pattern for the leg.

The reference is a plain sample input that is taken on every clock while `en` is high. It has no handshake and no back-pressure, because a modulator consumes one sample per cycle by nature and cannot stall. The useful reference range is `-2H..+2H`. Values outside it saturate at the end levels. Dropping `en` or asserting `rst` parks the leg at the mid level and restarts the carrier sweep.

Top module: `pdm_modulator`

## Requirements
- R1: The shared carrier counter starts at 0, rising, after reset and during any cycle with `en` low. While enabled, each clock it rises by one until it reaches or exceeds `half_period`, then falls by one until it reaches 0, then rises again. With a fixed `H` this gives 0,1,..,H,H-1,..,1,0,1,...
- R2: With counter value `c`, the carriers are `c-2H`, `c-H`, `c` and `c+H`. The registered level equals the number of carriers strictly below the reference, minus 2. Level +2 means the reference is above both upper bands. Level -2 means it is below both lower bands.
- R3: A reference equal to a carrier does not count as above it, so a tie always resolves to the lower of the two candidate levels.
- R4: `gate_o` bit 7..4 drive upper switches 1..4 and bit 3..0 drive their complements 1'..4'. The pattern is 8'hF0 for level +2, 8'h78 for +1, 8'h3C for 0, 8'h1E for -1 and 8'h0F for -2. In other words, the pattern is 8'hF0 shifted right by (2 - level).
- R5: A switch and its complement (`gate_o[7-k]` and `gate_o[3-k]`) are never on in the same cycle.
- R6: Exactly four gate bits are on in every cycle, and they are contiguous.
- R7: `level_o` and `gate_o` are registered. They reflect the reference and counter values present before the rising edge, and change only on that edge.
- R8: In the cycle after `rst` is high or `en` is low, `level_o` is 0 and `gate_o` is 8'h3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Modulation enable |
| half_period | input | CW | Carrier half-period H in clocks, at least 1 |
| ref_sample | input | REF_W | Signed reference sample |
| level_o | output | 3 | Signed output level, -2..+2 |
| gate_o | output | 8 | Switch drives, upper four then complements |

## Verification
The assertions assume that `rst` is held high from time zero through the first edge, so every `$past` refers to a defined cycle. They also assume that `half_period` is never zero while enabled. The stimulus asserts reset at the start and again mid-run, and it only ever programs half-periods of 2 to 4. Reference ramps deliberately run one step beyond `±2H`, and they include values equal to each carrier. This exercises saturation and ties without leaving the assumed input space.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int unsigned NUM_BANDS = 4;
  localparam int unsigned NUM_SW    = 2 * NUM_BANDS;

  typedef logic signed [2:0] lvl_t;

  // On-window of four adjacent switches, shifted by one per level step
  function automatic logic [NUM_SW-1:0] gate_pattern(lvl_t l);
    int sh;
    sh = 2 - int'(l);
    return 8'hF0 >> sh;
  endfunction
endpackage

// File: rtl/pdm_carrier_gen.sv
module pdm_carrier_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] half_i,
  output logic [CW-1:0] cnt_o
);
  logic rising_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_o    <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      if (cnt_o >= half_i) begin
        rising_q <= 1'b0;
        cnt_o    <= cnt_o - 1'b1;
      end else begin
        cnt_o    <= cnt_o + 1'b1;
      end
    end else begin
      if (cnt_o == '0) begin
        rising_q <= 1'b1;
        cnt_o    <= cnt_o + 1'b1;
      end else begin
        cnt_o    <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdm_level_cmp.sv
module pdm_level_cmp
  import pdm_pkg::*;
#(
  parameter int CW    = 8,
  parameter int REF_W = CW + 3
) (
  input  logic                    run,
  input  logic [CW-1:0]           cnt_i,
  input  logic [CW-1:0]           half_i,
  input  logic signed [REF_W-1:0] ref_i,
  output lvl_t                    lvl_next_o
);
  localparam int PADW = REF_W - CW;

  logic signed [REF_W-1:0] cnt_s, half_s;
  logic signed [REF_W-1:0] carrier [NUM_BANDS];
  logic [NUM_BANDS-1:0]    above;

  assign cnt_s  = $signed({{PADW{1'b0}}, cnt_i});
  assign half_s = $signed({{PADW{1'b0}}, half_i});

  // Lowest band sits two half-periods below the counter
  assign carrier[0] = cnt_s - half_s - half_s;

  genvar k;
  generate
    for (k = 1; k < NUM_BANDS; k++) begin : g_band
      assign carrier[k] = carrier[k-1] + half_s;
    end
    for (k = 0; k < NUM_BANDS; k++) begin : g_cmp
      // strict compare: a tie counts as not above
      assign above[k] = (ref_i > carrier[k]);
    end
  endgenerate

  always_comb begin
    if (run) lvl_next_o = lvl_t'($countones(above) - 2);
    else     lvl_next_o = '0;
  end
endmodule

// File: rtl/pdm_gate_map.sv
module pdm_gate_map
  import pdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  lvl_t              lvl_next_i,
  output logic [NUM_SW-1:0] gate_o
);
  always_ff @(posedge clk) begin
    if (rst) gate_o <= gate_pattern(lvl_t'(0));
    else     gate_o <= gate_pattern(lvl_next_i);
  end
endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator
  import pdm_pkg::*;
#(
  parameter int CW    = 8,
  parameter int REF_W = CW + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [CW-1:0]           half_period,
  input  logic signed [REF_W-1:0] ref_sample,
  output logic signed [2:0]       level_o,
  output logic [7:0]              gate_o
);
  logic [CW-1:0] cnt;
  lvl_t          lvl_next;

  pdm_carrier_gen #(.CW(CW)) carrier_i (
    .clk(clk), .rst(rst), .run(en), .half_i(half_period), .cnt_o(cnt)
  );

  pdm_level_cmp #(.CW(CW), .REF_W(REF_W)) cmp_i (
    .run(en), .cnt_i(cnt), .half_i(half_period), .ref_i(ref_sample),
    .lvl_next_o(lvl_next)
  );

  pdm_gate_map map_i (
    .clk(clk), .rst(rst), .lvl_next_i(lvl_next), .gate_o(gate_o)
  );

  always_ff @(posedge clk) begin
    if (rst) level_o <= '0;
    else     level_o <= lvl_next;
  end
endmodule

// File: rtl/pdm_checks.sv
module pdm_checks
  import pdm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic signed [2:0] level,
  input logic [7:0]        gate
);
  function automatic bit contiguous(logic [7:0] g);
    logic [8:0] x;
    x = {1'b0, g} | ({1'b0, g} - 9'd1);
    return (g != 8'd0) && (((x + 9'd1) & {1'b0, g}) == 9'd0);
  endfunction

  assert_gate_matches_level_R4: assert property (@(posedge clk) disable iff (rst)
    gate == gate_pattern(level));

  assert_no_pair_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    (gate[7:4] & gate[3:0]) == 4'b0000);

  assert_four_adjacent_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(gate) == 4) && contiguous(gate));

  assert_idle_mid_level_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || !$past(en)) |-> (level == 3'sd0 && gate == 8'h3C));
endmodule

bind pdm_modulator pdm_checks chk_i (
  .clk(clk), .rst(rst), .en(en), .level(level_o), .gate(gate_o)
);

// File: tb/pdm_modulator_tb.sv
module pdm_modulator_tb_top;
  localparam int CW    = 8;
  localparam int REF_W = CW + 3;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    en  = 1'b0;
  logic [CW-1:0]           half_period = 8'd4;
  logic signed [REF_W-1:0] ref_sample = '0;
  logic signed [2:0]       level_o;
  logic [7:0]              gate_o;

  int nvec  = 0;
  int nfail = 0;
  int mcnt  = 0;
  bit mup   = 1'b1;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pdm_modulator #(.CW(CW), .REF_W(REF_W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .half_period(half_period),
    .ref_sample(ref_sample), .level_o(level_o), .gate_o(gate_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_gate(int lv);
    return (8'hF0 >> (2 - lv)) & 8'hFF;
  endfunction

  task automatic check_outputs(int el, string req);
    int g;
    g = int'(gate_o);
    check(int'(level_o) == el, req, int'(level_o), el);
    check(g == exp_gate(el), "R4", g, exp_gate(el));
    check((gate_o[7:4] & gate_o[3:0]) == 4'b0, "R5", g, exp_gate(el));
    check($countones(gate_o) == 4, "R6", $countones(gate_o), 4);
  endtask

  // Drive one sample, predict the registered result, check after the edge
  task automatic apply(int r, bit e, int h);
    int el, n;
    bit tie;
    en = e; half_period = CW'(h); ref_sample = REF_W'(r);
    tie = 1'b0;
    if (!e) el = 0;
    else begin
      n = 0;
      for (int k = -2; k <= 1; k++) begin
        if (r > mcnt + k * h) n++;
        if (r == mcnt + k * h) tie = 1'b1;
      end
      el = n - 2;
    end
    // R1 model of the shared triangle counter
    if (!e) begin mcnt = 0; mup = 1'b1; end
    else if (mup) begin
      if (mcnt >= h) begin mup = 1'b0; mcnt--; end else mcnt++;
    end else begin
      if (mcnt == 0) begin mup = 1'b1; mcnt++; end else mcnt--;
    end
    @(posedge clk);
    @(negedge clk);
    if (!e)       check_outputs(el, "R8");
    else if (tie) check_outputs(el, "R3");
    else          check_outputs(el, "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    @(posedge clk); @(negedge clk);
    check_outputs(0, "R8");
    rst = 1'b0;
    mcnt = 0; mup = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 R3: ramps against every counter phase, H = 3 and H = 4
    for (int h = 3; h <= 4; h++) begin
      for (int rep = 0; rep < 2 * h; rep++)
        for (int r = -2 * h - 1; r <= 2 * h + 1; r++)
          apply(r, 1'b1, h);
    end
    // R7: a single step in the reference shows up exactly one edge later
    apply(-9, 1'b1, 4);
    apply(9, 1'b1, 4);
    // R2: sampled sine at 95% of full scale
    for (int k = 0; k < 256; k++)
      apply(int'($rtoi(7.6 * $sin(6.283185307 * k / 64.0) + 8.5)) - 8, 1'b1, 4);
    // R8: disable mid-run, then counter restarts at 0 rising (R1)
    for (int k = 0; k < 4; k++) apply(8, 1'b0, 4);
    for (int k = 0; k < 20; k++) apply(k % 9 - 4, 1'b1, 2);
    // R1: half-period shrinks while counter is above the new value
    for (int k = 0; k < 4; k++) apply(0, 1'b1, 4);
    for (int k = 0; k < 24; k++) apply(k % 7 - 3, 1'b1, 2);
    // R8: reset mid-run
    do_reset();
    for (int r = -5; r <= 5; r++) apply(r, 1'b1, 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule